// File: doc/BRIEF.md
# Programmable-Period Gate Timing Generator

This block times the two power switches of a synchronous boost converter from one control clock, where one tick is 40 ns. A 4-bit period code selects the period of a square wave with a 50% duty cycle. The high half of that wave is the on-time of the low-side switch. The tick at which the low half begins drives the active-low high-side gate on for exactly one tick. Both on-times come from the same clock, so the ratio between them is always an exact integer.

The period is built in two stages. A ring stage counts a base of 4 to 7 ticks, and a binary divider chain repeats that base 1, 2, 4 or 8 times. This gives sixteen coarse steps of about 20% each. The code is captured when a cycle starts, so a later change applies only to the next cycle.

Cycles start only while the supervisor request is high. A cycle that has started always runs to its end, even if the request drops partway through.

The controller has five named states:
- IDLE: both gates off.
- CHARGE: low-side gate on, for half a period.
- RELEASE: high-side gate on, for one tick.
- SETTLE: both gates off; the cycle-done pulse is high for this one tick.
- REST: both gates off, until the half period that began at RELEASE has elapsed.

The transitions are:
- IDLE→CHARGE, when the request is high.
- CHARGE→RELEASE, when the phase timer expires.
- RELEASE→SETTLE and SETTLE→REST, each after one tick.
- REST→CHARGE, when the timer expires and the request is still high.
- REST→IDLE, when the timer expires and the request is low.

Top module: `gate_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are `ls_gate`=0, `hs_gate_n`=1 and `cycle_done`=0.
- R2: Code c selects a full period P(c) in ticks. P(0) through P(15) are 112, 96, 80, 64, 56, 48, 40, 32, 28, 24, 20, 16, 14, 12, 10, 8, so a higher code gives a shorter period. `ls_gate` stays high for exactly P(c)/2 consecutive ticks.
- R3: While the request stays high, the low half lasts P(c)/2 ticks. During the low half `ls_gate` is 0, counted from the first `hs_gate_n` low tick. `ls_gate` then rises again at once, so cycles run back to back.
- R4: `hs_gate_n` goes low in the first tick after `ls_gate` falls and stays low for exactly one tick. `hs_gate_n` is never low while `ls_gate` is high.
- R5: `cycle_done` is high for one tick, in the tick in which `hs_gate_n` returns high.
- R6: In IDLE with the request low, both gates stay off. When the request is sampled high at an edge, `ls_gate` is high from that edge on.
- R7: If the request drops during a cycle, the cycle completes: the full high half, the high-side pulse and the full low half. After that no new cycle starts.
- R8: The code is captured at the edge that starts a cycle. A code change during a cycle has no effect on that cycle and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, one tick per period |
| rst_n | input | 1 | Active-low synchronous reset |
| period_code | input | 4 | Period select code; higher is shorter |
| run_req | input | 1 | Supervisor request; cycles start only while it is high |
| ls_gate | output | 1 | Low-side switch gate, active high |
| hs_gate_n | output | 1 | High-side switch gate, active low |
| cycle_done | output | 1 | One-tick pulse at the end of the high-side pulse |

## Verification
All outputs are registered from the next-state decode, so each result appears one edge after its cause. Once the request is sampled high, `ls_gate` is high by the following sample. `hs_gate_n` is low in the sample right after the last high `ls_gate` sample, and `cycle_done` is high one sample after that.

The bench drives inputs and samples outputs on the falling clock edge. It counts the high and low samples of each phase and compares the counts with the period table. A code change is placed mid-phase so that the check of the current cycle and the check of the next cycle separate cleanly.

// File: rtl/gt_pkg.sv
package gt_pkg;

    typedef enum logic [2:0] {
        GT_IDLE    = 3'd0,
        GT_CHARGE  = 3'd1,
        GT_RELEASE = 3'd2,
        GT_SETTLE  = 3'd3,
        GT_REST    = 3'd4
    } gt_state_e;

    // Half period in ticks for each code; checkers use this as an
    // independent reference to the ring/divider decomposition.
    function automatic int gt_half_ticks(input logic [3:0] code);
        int p;
        unique case (code)
            4'd0:  p = 112;
            4'd1:  p = 96;
            4'd2:  p = 80;
            4'd3:  p = 64;
            4'd4:  p = 56;
            4'd5:  p = 48;
            4'd6:  p = 40;
            4'd7:  p = 32;
            4'd8:  p = 28;
            4'd9:  p = 24;
            4'd10: p = 20;
            4'd11: p = 16;
            4'd12: p = 14;
            4'd13: p = 12;
            4'd14: p = 10;
            default: p = 8;
        endcase
        return p / 2;
    endfunction

endpackage

// File: rtl/gt_code_decode.sv
module gt_code_decode #(
    parameter int FINE_W       = 2,
    parameter int COARSE_W     = 2,
    parameter int RING_LONGEST = 7,
    localparam int DIV_STAGES  = (1 << COARSE_W) - 1,
    localparam int RING_W      = $clog2(RING_LONGEST + 1),
    localparam int EXP_W       = $clog2(DIV_STAGES + 1)
) (
    input  logic [FINE_W+COARSE_W-1:0] code,
    output logic [RING_W-1:0]          ring_len,
    output logic [EXP_W-1:0]           div_exp
);
    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse;

    assign fine   = code[FINE_W-1:0];
    assign coarse = code[FINE_W+COARSE_W-1:FINE_W];

    // Higher fine bits shorten the ring; higher coarse bits shorten the divider.
    always_comb begin
        ring_len = RING_W'(RING_LONGEST) - RING_W'(fine);
        div_exp  = EXP_W'(DIV_STAGES) - EXP_W'(coarse);
    end
endmodule

// File: rtl/gt_ring_stage.sv
module gt_ring_stage #(
    parameter int RING_LONGEST = 7,
    localparam int RING_W      = $clog2(RING_LONGEST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RING_W-1:0] ring_len,
    output logic              at_end
);
    logic [RING_W-1:0] pos;
    logic [RING_W-1:0] last_pos;

    assign last_pos = ring_len - RING_W'(1);
    assign at_end   = (pos == last_pos);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos <= '0;
        end else if (at_end) begin
            pos <= '0;
        end else begin
            pos <= pos + RING_W'(1);
        end
    end

    // R2
    ring_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_len != '0) |-> (pos <= last_pos));
endmodule

// File: rtl/gt_divider.sv
module gt_divider #(
    parameter int DIV_STAGES = 3,
    localparam int EXP_W     = $clog2(DIV_STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [EXP_W-1:0] div_exp,
    output logic             term
);
    logic [DIV_STAGES-1:0] stage;
    logic [DIV_STAGES-1:0] carry;
    logic [DIV_STAGES-1:0] mask;

    // Toggle-flop chain: stage i flips when every lower stage is set.
    generate
        for (genvar i = 0; i < DIV_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign carry[i] = adv;
            end else begin : g_next
                assign carry[i] = carry[i-1] & stage[i-1];
            end
            assign mask[i] = (EXP_W'(i) < div_exp);

            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    stage[i] <= 1'b0;
                end else if (carry[i]) begin
                    stage[i] <= ~stage[i];
                end
            end
        end
    endgenerate

    // Terminal once every stage below the selected exponent is set.
    assign term = &(stage | ~mask);
endmodule

// File: rtl/gate_timing_gen.sv
module gate_timing_gen
    import gt_pkg::*;
#(
    parameter int FINE_W       = 2,
    parameter int COARSE_W     = 2,
    parameter int RING_LONGEST = 7,
    parameter int RUN_W        = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FINE_W+COARSE_W-1:0] period_code,
    input  logic                       run_req,
    output logic                       ls_gate,
    output logic                       hs_gate_n,
    output logic                       cycle_done
);
    localparam int CODE_W     = FINE_W + COARSE_W;
    localparam int DIV_STAGES = (1 << COARSE_W) - 1;
    localparam int RING_W     = $clog2(RING_LONGEST + 1);
    localparam int EXP_W      = $clog2(DIV_STAGES + 1);

    gt_state_e          state, state_nx;
    logic               start;
    logic [CODE_W-1:0]  code_q;
    logic [RING_W-1:0]  ring_len;
    logic [EXP_W-1:0]   div_exp;
    logic               ring_end;
    logic               div_term;
    logic               phase_last;
    logic               tmr_clr;

    gt_code_decode #(
        .FINE_W(FINE_W), .COARSE_W(COARSE_W), .RING_LONGEST(RING_LONGEST)
    ) u_decode (
        .code(code_q), .ring_len(ring_len), .div_exp(div_exp)
    );

    gt_ring_stage #(.RING_LONGEST(RING_LONGEST)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
        .ring_len(ring_len), .at_end(ring_end)
    );

    gt_divider #(.DIV_STAGES(DIV_STAGES)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .adv(ring_end),
        .div_exp(div_exp), .term(div_term)
    );

    assign phase_last = ring_end & div_term;
    assign tmr_clr    = (state == GT_IDLE) | phase_last;

    // Next-state decode
    always_comb begin
        state_nx = state;
        start    = 1'b0;
        unique case (state)
            GT_IDLE: begin
                if (run_req) begin
                    state_nx = GT_CHARGE;
                    start    = 1'b1;
                end
            end
            GT_CHARGE: begin
                if (phase_last) state_nx = GT_RELEASE;
            end
            GT_RELEASE: state_nx = GT_SETTLE;
            GT_SETTLE:  state_nx = GT_REST;
            GT_REST: begin
                if (phase_last) begin
                    if (run_req) begin
                        state_nx = GT_CHARGE;
                        start    = 1'b1;
                    end else begin
                        state_nx = GT_IDLE;
                    end
                end
            end
            default: state_nx = GT_IDLE;
        endcase
    end

    // State register and code capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= GT_IDLE;
            code_q <= '0;
        end else begin
            state <= state_nx;
            if (start) code_q <= period_code;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_gate    <= 1'b0;
            hs_gate_n  <= 1'b1;
            cycle_done <= 1'b0;
        end else begin
            ls_gate    <= (state_nx == GT_CHARGE);
            hs_gate_n  <= (state_nx != GT_RELEASE);
            cycle_done <= (state_nx == GT_SETTLE);
        end
    end

    // Checker state: length of the current low-side run
    logic [RUN_W-1:0] ls_run;
    always_ff @(posedge clk) begin
        if (!rst_n) ls_run <= '0;
        else        ls_run <= ls_gate ? ls_run + RUN_W'(1) : '0;
    end

    // R2
    ls_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_gate) |-> (int'(ls_run) == gt_half_ticks(4'(code_q))));
    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_gate && !hs_gate_n));
    // R4
    hs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_gate) |-> !hs_gate_n);
    // R4
    hs_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_gate_n |=> hs_gate_n);
    // R5
    done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_n) |-> cycle_done);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GT_IDLE && !run_req) |=> !ls_gate);
    // R7
    cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GT_CHARGE || state == GT_RELEASE || state == GT_SETTLE)
        |=> (state != GT_IDLE));
endmodule

// File: tb/gate_timing_gen_bench.sv
module gate_timing_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] period_code;
    logic       run_req;
    logic       ls_gate, hs_gate_n, cycle_done;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    int  period_tbl [16] = '{112, 96, 80, 64, 56, 48, 40, 32,
                             28, 24, 20, 16, 14, 12, 10, 8};

    always #5 clk = ~clk;

    gate_timing_gen u_gate_timing_gen (
        .clk(clk), .rst_n(rst_n), .period_code(period_code),
        .run_req(run_req), .ls_gate(ls_gate), .hs_gate_n(hs_gate_n),
        .cycle_done(cycle_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (ls_gate === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (ls_gate === 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic go_idle;
        run_req = 1'b0;
        repeat (240) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; run_req = 1'b0; period_code = 4'd0;
        repeat (3) @(negedge clk);
        chk(ls_gate === 1'b0, "R1 ls_gate in reset", int'(ls_gate), 0);
        chk(hs_gate_n === 1'b1, "R1 hs_gate_n in reset", int'(hs_gate_n), 1);
        chk(cycle_done === 1'b0, "R1 cycle_done in reset", int'(cycle_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ls_gate === 1'b0 && hs_gate_n === 1'b1, "R1 after release",
            int'(ls_gate), 0);
    endtask

    task automatic t_idle;
        int active = 0;
        run_req = 1'b0; period_code = 4'd9;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ls_gate !== 1'b0 || hs_gate_n !== 1'b1 || cycle_done !== 1'b0) active++;
        end
        chk(active == 0, "R6 idle holds gates off", active, 0);
    endtask

    task automatic t_cycle(input int code);
        int h = period_tbl[code] / 2;
        int n, m;
        period_code = 4'(code); run_req = 1'b1;
        @(negedge clk);
        chk(ls_gate === 1'b1, "R6 start on request", int'(ls_gate), 1);
        count_high(n);
        chk(n == h, $sformatf("R2 high half code %0d", code), n, h);
        chk(hs_gate_n === 1'b0, "R4 hs pulse after ls falls", int'(hs_gate_n), 0);
        chk(cycle_done === 1'b0, "R5 no done during hs pulse", int'(cycle_done), 0);
        @(negedge clk);
        chk(hs_gate_n === 1'b1, "R4 hs pulse one tick", int'(hs_gate_n), 1);
        chk(cycle_done === 1'b1, "R5 done as hs returns", int'(cycle_done), 1);
        @(negedge clk);
        chk(cycle_done === 1'b0, "R5 done one tick", int'(cycle_done), 0);
        count_low(m);
        chk(m + 2 == h, $sformatf("R3 low half code %0d", code), m + 2, h);
        chk(ls_gate === 1'b1, "R3 back-to-back restart", int'(ls_gate), 1);
        go_idle();
    endtask

    task automatic t_change;
        int n, m;
        period_code = 4'd0; run_req = 1'b1;
        @(negedge clk);
        period_code = 4'd15;
        count_high(n);
        chk(n == 56, "R8 mid-cycle code change ignored", n, 56);
        count_low(m);
        chk(m == 56, "R8 low half keeps captured code", m, 56);
        count_high(n);
        chk(n == 4, "R8 new code on next cycle", n, 4);
        go_idle();
    endtask

    task automatic t_drop;
        int n, m;
        int highs = 0;
        period_code = 4'd3; run_req = 1'b1;
        @(negedge clk);
        repeat (4) @(negedge clk);
        run_req = 1'b0;
        count_high(n);
        chk(n + 4 == 32, "R7 high half completes after drop", n + 4, 32);
        chk(hs_gate_n === 1'b0, "R7 hs pulse still issued", int'(hs_gate_n), 0);
        @(negedge clk);
        chk(cycle_done === 1'b1, "R7 cycle done issued", int'(cycle_done), 1);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (ls_gate !== 1'b0) highs++;
        end
        chk(highs == 0, "R7 no new cycle after drop", highs, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_cycle(0);
        t_cycle(5);
        t_cycle(10);
        t_cycle(12);
        t_cycle(15);
        t_cycle(7);
        t_change();
        t_drop();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule